// File: doc/BRIEF.md
# High-Speed USB Root Port Status Register

This block holds the status and control word of a single root-hub port in a high-speed USB host controller. Software reads the word at any time and writes it with a one-cycle strobe. The device side reports three kinds of event: a device attaching, with a flag that says whether it runs at high speed; a device detaching; and a one-cycle I/O error pulse.

Each bit follows its own write rule. The change flags are cleared by writing a one to them. The port-enable bit can be cleared by software but never set by it. A small group of control bits, including port reset and the two wake enables, stores whatever software writes. Every other bit ignores the written data. Software alone starts and ends a port reset. The port becomes enabled only when a reset ends while a connected high-speed device is present. The enable-change flag records I/O errors on an enabled port, and nothing else sets it.

All updates take effect at the clock edge that samples the write or the event. A read returns the current register value and changes nothing.

Top module: `hsport_stat_reg`

## Requirements
- R1: After synchronous reset the register reads 0x00000000.
- R2: On a write, bits 6, 7, 8, 13, 20, 21 and 22 (mask 0x007021C0) take the written value. Bit 4, bits 9 to 12, bits 14 to 19 and bits 23 to 31 stay 0 whatever is written.
- R3: On a write, each of bits 1, 3 and 5 (mask 0x0000002A) is cleared where the written data has a 1, and is left unchanged where the written data has a 0.
- R4: Writing 0 to bit 2 (port enabled) clears it. Writing 1 to bit 2 leaves it unchanged.
- R5: A write that takes bit 8 (port reset) from 0 to 1 clears bit 2.
- R6: A write that takes bit 8 from 1 to 0 sets bit 2 if bit 0 is 1 and the attached device reported high speed. Otherwise bit 2 stays 0.
- R7: Bit 3 (enable change) is never set by reset completion, by a software clear of bit 2, or by a detach.
- R8: An I/O error pulse sets bit 3 if bit 2 is 1 in that cycle. If bit 2 is 0, the pulse has no effect.
- R9: An attach pulse without a detach sets bit 0 (connected) and bit 1 (connect change), and records the high-speed flag.
- R10: A detach pulse clears bit 0 and bit 2 and sets bit 1. If attach and detach arrive together, the detach wins.
- R11: If a write clears a change flag in the same cycle that a hardware event sets it, the flag ends up set.
- R12: Bits 21 and 22 (wake enables) are plain read/write bits. Their values do not depend on port events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Current register value |
| dev_attach | input | 1 | Device attach pulse |
| dev_detach | input | 1 | Device detach pulse |
| dev_hs | input | 1 | Attaching device runs at high speed (sampled with dev_attach) |
| io_err | input | 1 | I/O error pulse |

## Verification
Every result is held in the register itself, so a write or an event shows on sw_rdata one cycle after the rising edge that samples it. That includes reset entry, reset completion, attach, detach, error flags and write-one-to-clear effects. The bench changes inputs on the falling edge, lets exactly one rising edge pass, and compares sw_rdata on the next falling edge. The events are pulses, so they return to idle before the next rising edge can sample them again. The cases where two things happen in the same cycle are applied within a single step, so that the single captured result shows which rule won.

// File: rtl/pstat_pkg.sv
package pstat_pkg;
  localparam int REG_W = 32;

  localparam int CONN_B      = 0;
  localparam int CONN_CHG_B  = 1;
  localparam int EN_B        = 2;
  localparam int EN_CHG_B    = 3;
  localparam int OC_CHG_B    = 5;
  localparam int PRST_B      = 8;
  localparam int WAKE_DISC_B = 21;
  localparam int WAKE_OC_B   = 22;

  localparam logic [REG_W-1:0] RW_MASK   = 32'h0070_21C0;
  localparam logic [REG_W-1:0] W1C_MASK  = (REG_W'(1) << CONN_CHG_B) |
                                           (REG_W'(1) << EN_CHG_B)   |
                                           (REG_W'(1) << OC_CHG_B);
  localparam logic [REG_W-1:0] STAT_MASK = W1C_MASK | (REG_W'(1) << CONN_B) |
                                           (REG_W'(1) << EN_B);
  localparam logic [REG_W-1:0] USED_MASK = RW_MASK | STAT_MASK;

  // Merge software data into the directly writable field.
  function automatic logic [REG_W-1:0] f_rw_merge(input logic [REG_W-1:0] cur,
                                                  input logic [REG_W-1:0] wd);
    return (cur & ~RW_MASK) | (wd & RW_MASK);
  endfunction

  // Bits that a write-one-to-clear write removes.
  function automatic logic [REG_W-1:0] f_w1c_bits(input logic [REG_W-1:0] wd);
    return wd & W1C_MASK;
  endfunction
endpackage

// File: rtl/pstat_sw_path.sv
module pstat_sw_path
  import pstat_pkg::*;
(
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] cur,
  output logic [REG_W-1:0] merged,
  output logic [REG_W-1:0] w1c_clr,
  output logic             en_clr,
  output logic             rst_enter,
  output logic             rst_exit
);
  always_comb begin
    merged    = wr ? f_rw_merge(cur, wdata) : cur;
    w1c_clr   = wr ? f_w1c_bits(wdata) : '0;
    en_clr    = wr && !wdata[EN_B];
    rst_enter = wr && !cur[PRST_B] &&  wdata[PRST_B];
    rst_exit  = wr &&  cur[PRST_B] && !wdata[PRST_B];
  end
endmodule

// File: rtl/pstat_hw_events.sv
module pstat_hw_events
  import pstat_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic attach,
  input  logic detach,
  input  logic hs,
  input  logic io_err,
  input  logic cur_en,
  output logic conn_set,
  output logic conn_clr,
  output logic pedc_set,
  output logic dev_is_hs
);
  logic hs_q;

  always_ff @(posedge clk) begin
    if (rst)                   hs_q <= 1'b0;
    else if (detach)           hs_q <= 1'b0;
    else if (attach)           hs_q <= hs;
  end

  always_comb begin
    conn_clr  = detach;
    conn_set  = attach && !detach;
    pedc_set  = io_err && cur_en;
    dev_is_hs = hs_q;
  end
endmodule

// File: rtl/hsport_stat_reg.sv
module hsport_stat_reg
  import pstat_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_wr,
  input  logic [REG_W-1:0] sw_wdata,
  output logic [REG_W-1:0] sw_rdata,
  input  logic             dev_attach,
  input  logic             dev_detach,
  input  logic             dev_hs,
  input  logic             io_err
);
  logic [REG_W-1:0] q, nxt, merged, w1c_clr;
  logic en_clr_sw, rst_enter, rst_exit;
  logic conn_set, conn_clr, pedc_set, dev_is_hs;
  logic en_set_evt, en_clr_evt;

  pstat_sw_path u_sw (
    .wr(sw_wr), .wdata(sw_wdata), .cur(q), .merged(merged), .w1c_clr(w1c_clr),
    .en_clr(en_clr_sw), .rst_enter(rst_enter), .rst_exit(rst_exit)
  );

  pstat_hw_events u_hw (
    .clk(clk), .rst(rst), .attach(dev_attach), .detach(dev_detach), .hs(dev_hs),
    .io_err(io_err), .cur_en(q[EN_B]), .conn_set(conn_set), .conn_clr(conn_clr),
    .pedc_set(pedc_set), .dev_is_hs(dev_is_hs)
  );

  assign en_set_evt = rst_exit && q[CONN_B] && dev_is_hs && !conn_clr;
  assign en_clr_evt = en_clr_sw || rst_enter || conn_clr;

  always_comb begin
    nxt = merged & ~w1c_clr;
    if (en_clr_evt) nxt[EN_B] = 1'b0;
    if (en_set_evt) nxt[EN_B] = 1'b1;
    if (conn_set) begin
      nxt[CONN_B]     = 1'b1;
      nxt[CONN_CHG_B] = 1'b1;
    end
    if (conn_clr) begin
      nxt[CONN_B]     = 1'b0;
      nxt[EN_B]       = 1'b0;
      nxt[CONN_CHG_B] = 1'b1;
    end
    if (pedc_set) nxt[EN_CHG_B] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  assign sw_rdata = q;
endmodule

// File: rtl/pstat_chk.sv
module pstat_chk
  import pstat_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             sw_wr,
  input logic [REG_W-1:0] sw_wdata,
  input logic             dev_attach,
  input logic             dev_detach,
  input logic             io_err,
  input logic [REG_W-1:0] q,
  input logic             en_set_evt
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  a_r2_unused_zero: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (q & ~USED_MASK) == '0);

  a_r5_enter_disables: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(sw_wr && sw_wdata[PRST_B] && !q[PRST_B]) |-> !q[EN_B]);

  a_r6_enable_only_on_exit: assert property (@(posedge clk) disable iff (rst)
    past_ok && $rose(q[EN_B]) |-> $past(q[PRST_B]) && !q[PRST_B] && $past(en_set_evt));

  a_r8_pedc_from_error: assert property (@(posedge clk) disable iff (rst)
    past_ok && $rose(q[EN_CHG_B]) |-> $past(io_err && q[EN_B]));

  a_r9_attach_sets: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(dev_attach && !dev_detach) |-> q[CONN_B] && q[CONN_CHG_B]);

  a_r10_detach_clears: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(dev_detach) |-> !q[CONN_B] && !q[EN_B] && q[CONN_CHG_B]);
endmodule

bind hsport_stat_reg pstat_chk u_chk (
  .clk(clk), .rst(rst), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
  .dev_attach(dev_attach), .dev_detach(dev_detach), .io_err(io_err),
  .q(sw_rdata), .en_set_evt(en_set_evt)
);

// File: tb/test_hsport_stat_reg.sv
`timescale 1ns/1ps
module test_hsport_stat_reg;
  logic clk = 1'b0, rst = 1'b1;
  logic sw_wr = 1'b0, dev_attach = 1'b0, dev_detach = 1'b0, dev_hs = 1'b0, io_err = 1'b0;
  logic [31:0] sw_wdata = '0, sw_rdata;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  hsport_stat_reg i_hsport_stat_reg (
    .clk(clk), .rst(rst), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .dev_attach(dev_attach), .dev_detach(dev_detach), .dev_hs(dev_hs), .io_err(io_err)
  );

  // {wr, wdata, attach, detach, hs, err, expected}
  localparam int NV = 20;
  localparam logic [68:0] VEC [NV] = '{
    {1'b1, 32'hFFFF_FFFF, 4'b0000, 32'h0070_21C0},
    {1'b1, 32'h0000_0000, 4'b0000, 32'h0000_0000},
    {1'b0, 32'h0000_0000, 4'b1010, 32'h0000_0003},
    {1'b1, 32'h0000_0002, 4'b0000, 32'h0000_0001},
    {1'b1, 32'h0000_0100, 4'b0000, 32'h0000_0101},
    {1'b1, 32'h0000_0000, 4'b0000, 32'h0000_0005},
    {1'b1, 32'h0000_0004, 4'b0000, 32'h0000_0005},
    {1'b0, 32'h0000_0000, 4'b0001, 32'h0000_000D},
    {1'b1, 32'h0000_000C, 4'b0000, 32'h0000_0005},
    {1'b1, 32'h0000_0000, 4'b0000, 32'h0000_0001},
    {1'b0, 32'h0000_0000, 4'b0001, 32'h0000_0001},
    {1'b1, 32'h0060_0000, 4'b0000, 32'h0060_0001},
    {1'b1, 32'h0060_0100, 4'b0000, 32'h0060_0101},
    {1'b1, 32'h0060_0000, 4'b0000, 32'h0060_0005},
    {1'b0, 32'h0000_0000, 4'b0100, 32'h0060_0002},
    {1'b1, 32'h0060_0002, 4'b1000, 32'h0060_0003},
    {1'b1, 32'h0060_0100, 4'b0000, 32'h0060_0103},
    {1'b1, 32'h0060_0000, 4'b0000, 32'h0060_0003},
    {1'b1, 32'h0000_9E10, 4'b0000, 32'h0000_0003},
    {1'b1, 32'h0000_0020, 4'b0000, 32'h0000_0003}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0, 18:        return "R2";
      3, 8, 19:     return "R3";
      6:            return "R4";
      4, 12, 16:    return "R5";
      1, 5, 13, 17: return "R6";
      9:            return "R7";
      7, 10:        return "R8";
      2:            return "R9";
      14:           return "R10";
      15:           return "R11";
      11:           return "R12";
      default:      return "R?";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] exp);
    checks++;
    if (sw_rdata !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, sw_rdata, exp);
    end
  endtask

  // Drive after a falling edge, one rising edge captures, sample at next falling edge.
  task automatic step(input logic wr, input logic [31:0] wd, input logic [3:0] ev,
                      input string tag, input logic [31:0] exp);
    sw_wr = wr; sw_wdata = wd;
    {dev_attach, dev_detach, dev_hs, io_err} = ev;
    @(negedge clk);
    sw_wr = 1'b0; sw_wdata = '0;
    {dev_attach, dev_detach, dev_hs, io_err} = 4'b0000;
    check(tag, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset value", 32'h0);
    for (int i = 0; i < NV; i++)
      step(VEC[i][68], VEC[i][67:36], VEC[i][35:32], vec_tag(i), VEC[i][31:0]);
    // R10: detach from current state, then high-speed attach, reset cycle to enable.
    step(1'b0, 32'h0, 4'b0100, "R10 detach", 32'h0000_0002);
    step(1'b0, 32'h0, 4'b1110, "R10 attach+detach same cycle", 32'h0000_0002);
    step(1'b0, 32'h0, 4'b1010, "R9 attach hs", 32'h0000_0003);
    step(1'b1, 32'h0000_0100, 4'b0000, "R5 enter reset", 32'h0000_0103);
    step(1'b1, 32'h0000_0000, 4'b0000, "R6 exit reset hs", 32'h0000_0007);
    // R11: error sets bit 3 while the same write clears bits 1 and 3.
    step(1'b1, 32'h0000_000E, 4'b0001, "R11 hw set beats w1c", 32'h0000_000D);
    // R7: detach while enabled must not touch bit 3 (bit 3 cleared first).
    step(1'b1, 32'h0000_000C, 4'b0000, "R3 clear bit 3", 32'h0000_0005);
    step(1'b0, 32'h0, 4'b0100, "R7 detach no pedc", 32'h0000_0002);
    // R12: wake bits hold through attach.
    step(1'b1, 32'h0040_0000, 4'b0000, "R12 wake oc only", 32'h0040_0002);
    step(1'b0, 32'h0, 4'b1010, "R12 wake kept on attach", 32'h0040_0003);
    // R1: reset in mid-operation.
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset clears all", 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule